// File: doc/BRIEF.md
# Bus Cycle Termination Arbiter

This block watches the three asynchronous termination inputs of an external bus cycle: acknowledge, bus error and halt. It resolves them into a single outcome for each cycle. The bus controller starts a cycle with a one-clock start pulse and states whether the cycle is an instruction fetch. The block then synchronizes the termination inputs and waits for one of them. When the cycle is decided, it raises a one-clock done strobe together with a one-hot result code.

An acknowledge is not final at the moment it is recognized. The block keeps a one-clock window open after it, and a bus error that arrives inside that window still turns the cycle into an error. A bus error seen together with halt asks for the cycle to be retried. A cycle that receives no termination within a programmable number of clocks is closed as an error, so the block also serves as a bus monitor. On an error, a data cycle signals that the exception is due at once. A fetch cycle only marks the fetched word, and the exception waits until that word is used.

Top module: `bus_term_arbiter`

## Requirements
- R1: After reset, done, result, exc_now, fetch_tag and busy are all 0.
- R2: A bus error with halt and acknowledge negated ends the cycle with result error (result bit 1).
- R3: When acknowledge and bus error are recognized on the same clock, the cycle ends as error, not ok.
- R4: A bus error that arrives one clock after acknowledge ends the cycle as error. A bus error that arrives two clocks after acknowledge is ignored, and the cycle ends ok (result bit 0).
- R5: An acknowledge applied together with cyc_start and held ends the cycle as ok. Done is high after the fourth rising edge, counting the edge that samples cyc_start: two synchronizer stages, one recognition edge and one late-error window.
- R6: A bus error with halt asserted ends the cycle as retry (result bit 2), and neither exc_now nor fetch_tag is raised.
- R7: result is one-hot (bit 0 ok, bit 1 error, bit 2 retry) while done is high and is zero otherwise. done lasts exactly one clock.
- R8: On an error outcome, exc_now is 1 for a data cycle and fetch_tag is 1 for a fetch cycle. The two are never both high, and they are never high without an error outcome.
- R9: A cycle with no termination input ends as error, with done high after edge tmo_limit+1, counting the edge that samples cyc_start. Halt alone is not a termination.
- R10: A termination recognized on the same edge on which the timeout expires takes precedence over the timeout.
- R11: A cyc_start pulse while a cycle is in progress is ignored and does not begin a second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse that opens a bus cycle |
| cyc_is_fetch | input | 1 | The cycle being opened is an instruction fetch |
| tmo_limit | input | TW | Bus monitor limit in clocks, 1 or more |
| ack_in | input | 1 | Asynchronous acknowledge, active high |
| berr_in | input | 1 | Asynchronous bus error, active high |
| halt_in | input | 1 | Asynchronous halt, active high |
| busy | output | 1 | A cycle is being tracked |
| done | output | 1 | One-clock cycle-complete strobe |
| result | output | 3 | One-hot outcome: bit 0 ok, bit 1 error, bit 2 retry |
| exc_now | output | 1 | Error on a data cycle: raise the exception now |
| fetch_tag | output | 1 | Error on a fetch: mark the fetched word |

## Verification
Two decisions can land on the same clock. The first is the arrival of acknowledge against either the bus monitor expiry or a bus error. The second is a late bus error against the closing of the window that follows acknowledge. The bench delays acknowledge by one clock under a limit of three, which makes acknowledge and expiry meet on one edge, and it judges that the cycle ends ok one clock later than a timeout would have ended it. It also applies acknowledge and bus error together, and bus error one or two clocks after acknowledge, and it checks that only the error that falls inside the window overrides the acknowledge.

// File: rtl/bterm_pkg.sv
package bterm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LATE = 2'd2
  } bterm_st_t;

  localparam int RES_W   = 3;
  localparam int RES_OK  = 0;
  localparam int RES_ERR = 1;
  localparam int RES_RTY = 2;

  localparam int IN_ACK  = 0;
  localparam int IN_BERR = 1;
  localparam int IN_HALT = 2;
  localparam int IN_W    = 3;
endpackage

// File: rtl/bterm_sync.sv
module bterm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/bterm_timer.sv
module bterm_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic [TW:0]   nxt;

  assign nxt     = {1'b0, cnt} + 1'b1;
  assign expired = en && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && !(&cnt)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bterm_fsm.sv
module bterm_fsm
  import bterm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_fetch,
  input  logic             ack_s,
  input  logic             berr_s,
  input  logic             halt_s,
  input  logic             expired,
  output logic             tmr_clr,
  output logic             tmr_en,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             exc_now,
  output logic             fetch_tag
);
  bterm_st_t        st, st_nx;
  logic             fetch_q;
  logic             fin;
  logic [RES_W-1:0] code;

  always_comb begin
    st_nx = st;
    fin   = 1'b0;
    code  = '0;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_WAIT;
      ST_WAIT: begin
        if (berr_s && halt_s) begin
          fin = 1'b1; code[RES_RTY] = 1'b1;
        end else if (berr_s) begin
          fin = 1'b1; code[RES_ERR] = 1'b1;
        end else if (ack_s) begin
          st_nx = ST_LATE;
        end else if (expired) begin
          fin = 1'b1; code[RES_ERR] = 1'b1;
        end
      end
      ST_LATE: begin
        fin = 1'b1;
        if (berr_s && halt_s) code[RES_RTY] = 1'b1;
        else if (berr_s)      code[RES_ERR] = 1'b1;
        else                  code[RES_OK]  = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
    if (fin) st_nx = ST_IDLE;
  end

  assign tmr_clr = (st == ST_IDLE);
  assign tmr_en  = (st == ST_WAIT);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      fetch_q   <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      exc_now   <= 1'b0;
      fetch_tag <= 1'b0;
    end else begin
      st        <= st_nx;
      done      <= fin;
      result    <= code;
      exc_now   <= fin && code[RES_ERR] && !fetch_q;
      fetch_tag <= fin && code[RES_ERR] && fetch_q;
      if (st == ST_IDLE && start) fetch_q <= is_fetch;
    end
  end
endmodule

// File: rtl/bus_term_arbiter.sv
module bus_term_arbiter
  import bterm_pkg::*;
#(
  parameter int TW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_start,
  input  logic          cyc_is_fetch,
  input  logic [TW-1:0] tmo_limit,
  input  logic          ack_in,
  input  logic          berr_in,
  input  logic          halt_in,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic          exc_now,
  output logic          fetch_tag
);
  logic [IN_W-1:0] raw, syn;
  logic tmr_clr, tmr_en, expired;

  always_comb begin
    raw          = '0;
    raw[IN_ACK]  = ack_in;
    raw[IN_BERR] = berr_in;
    raw[IN_HALT] = halt_in;
  end

  bterm_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  bterm_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en),
    .limit(tmo_limit), .expired(expired)
  );

  bterm_fsm u_fsm (
    .clk(clk), .rst(rst), .start(cyc_start), .is_fetch(cyc_is_fetch),
    .ack_s(syn[IN_ACK]), .berr_s(syn[IN_BERR]), .halt_s(syn[IN_HALT]),
    .expired(expired), .tmr_clr(tmr_clr), .tmr_en(tmr_en),
    .busy(busy), .done(done), .result(result),
    .exc_now(exc_now), .fetch_tag(fetch_tag)
  );
endmodule

// File: rtl/bterm_checker.sv
module bterm_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] tmo_limit,
  input logic          busy,
  input logic          done,
  input logic [2:0]    result,
  input logic          exc_now,
  input logic          fetch_tag
);
  logic [TW+1:0] bcnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else if (!(&bcnt)) bcnt <= bcnt + 1'b1;
  end

  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot(result));
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    !done |-> (result == 3'b000));
  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_excl: assert property (@(posedge clk) disable iff (rst)
    (exc_now || fetch_tag) |-> (done && result[1] && !(exc_now && fetch_tag)));
  a_r6_no_exc: assert property (@(posedge clk) disable iff (rst)
    (done && result[2]) |-> (!exc_now && !fetch_tag));
  a_r9_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt <= {2'b00, tmo_limit} + 2));
endmodule

bind bus_term_arbiter bterm_checker #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .tmo_limit(tmo_limit), .busy(busy), .done(done),
  .result(result), .exc_now(exc_now), .fetch_tag(fetch_tag)
);

// File: tb/sim_bus_term_arbiter.sv
`timescale 1ns/1ps
module sim_bus_term_arbiter;
  localparam int TW = 8;
  logic clk = 0, rst = 1;
  logic cyc_start = 0, cyc_is_fetch = 0, ack_in = 0, berr_in = 0, halt_in = 0;
  logic [TW-1:0] tmo_limit = 8'd10;
  logic busy, done, exc_now, fetch_tag;
  logic [2:0] result;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bus_term_arbiter #(.TW(TW)) u0 (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_is_fetch(cyc_is_fetch),
    .tmo_limit(tmo_limit), .ack_in(ack_in), .berr_in(berr_in), .halt_in(halt_in),
    .busy(busy), .done(done), .result(result), .exc_now(exc_now), .fetch_tag(fetch_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kinds: 0 ack, 1 berr, 2 berr+halt, 3 ack then berr +1, 4 ack then berr +2,
  // 5 nothing, 6 halt only, 7 ack+berr together, 8 ack +1 on timeout edge
  function automatic logic [2:0] exp_res(input int k);
    case (k)
      0, 4, 8: return 3'b001;
      2:       return 3'b100;
      default: return 3'b010;
    endcase
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0: return "R5"; 1: return "R2"; 2: return "R6"; 3: return "R4";
      4: return "R4"; 5: return "R9"; 6: return "R9"; 7: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input int k, input bit fetch, input int lim, input bit extra);
    int n = 0;
    logic [2:0] er;
    @(negedge clk);
    tmo_limit = lim[TW-1:0];
    cyc_start = 1; cyc_is_fetch = fetch;
    if (k == 0 || k == 3 || k == 4 || k == 7) ack_in = 1;
    if (k == 1 || k == 2 || k == 7) berr_in = 1;
    if (k == 2 || k == 6) halt_in = 1;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      cyc_start = 0;
      if (extra && n == 2) cyc_start = 1;
      if (k == 3 && n == 1) berr_in = 1;
      if (k == 4 && n == 2) berr_in = 1;
      if (k == 8 && n == 1) ack_in = 1;
      if (done || n > 300) break;
    end
    er = exp_res(k);
    chk(done === 1'b1, req_of(k), int'(done), 1);
    chk(result === er, req_of(k), int'(result), int'(er));
    chk(exc_now === (er[1] && !fetch), "R8", int'(exc_now), int'(er[1] && !fetch));
    chk(fetch_tag === (er[1] && fetch), "R8", int'(fetch_tag), int'(er[1] && fetch));
    if (k == 0) chk(n == 4, "R5", n, 4);
    if (k == 5 || k == 6) chk(n == lim + 1, "R9", n, lim + 1);
    if (k == 8) chk(n == 5, "R10", n, 5);
    cyc_start = 0; ack_in = 0; berr_in = 0; halt_in = 0;
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0 && result === 3'b000, "R7", int'(done), 0);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      if (extra) chk(done === 1'b0 && busy === 1'b0, "R11", int'(busy), 0);
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, k, lim;
    s = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(done === 0 && result === 0 && exc_now === 0 && fetch_tag === 0 && busy === 0,
        "R1", int'(busy), 0);
    for (int d = 0; d < 8; d++) run(d, 1'b0, 12, 1'b0);
    run(1, 1'b1, 12, 1'b0);
    run(0, 1'b0, 12, 1'b1);
    run(8, 1'b0, 3, 1'b0);
    run(5, 1'b1, 1, 1'b0);
    for (int i = 0; i < 80; i++) begin
      k = $urandom_range(0, 7);
      lim = (k == 5 || k == 6) ? $urandom_range(2, 20) : $urandom_range(8, 20);
      run(k, 1'($urandom_range(0, 1)), lim, 1'($urandom_range(0, 1)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule